// File: doc/BRIEF.md
# Message Memory Row Sequencer

This block walks a row pointer through a message store while the store is recording, playing back or fast-forwarding. A host command gives a start row and an operating mode. From then on the sequencer holds each row for one row period and then moves to the next row. During each row period it drives a row clock. The row clock sits released (high) for the first part of the period and is pulled low for the short tail. Fast-forward uses the same waveform shape with shorter phases.

Two row-level events end an operation and latch a sticky flag. The first is a stored end-of-message marker, which counts only during playback. The second is the pointer reaching the last row, which counts in every mode. A start row outside the store raises the overflow flag immediately. A stop request lets the current row period finish before the sequencer returns to idle.

The row clock leaves the block as a pull-down enable for an external open-drain output stage. A 1 means the line is pulled low; a 0 means the line is released to high impedance. All phase lengths are parameters counted in system clock ticks.

Top module: `msg_row_sequencer`

## Requirements
- R1: After reset, `busy_o`, `eom_o`, `ovf_o` and `rac_pull_o` are 0 and `row_o` is 0; while idle, `rac_pull_o` stays 0.
- R2: A `start_i` pulse while idle, with `start_row_i` below NUM_ROWS, loads that row into `row_o`, sets `busy_o` from the next cycle and latches `mode_i`. Mode encoding: 2'b00 record, 2'b01 playback, 2'b10 fast-forward, 2'b11 acts as record.
- R3: In record and playback, each row period is HI_TICKS cycles with `rac_pull_o`=0, then LO_TICKS cycles with `rac_pull_o`=1. `row_o` then increments by one and the next period begins with the released phase.
- R4: A `stop_i` pulse while busy lets the current row period complete. `busy_o` then drops, and `row_o` keeps the row of that period.
- R5: In fast-forward, the released phase lasts FF_HI_TICKS cycles and the pulled phase lasts FF_LO_TICKS cycles.
- R6: `marker_i` is sampled in the final cycle of each row period. In playback only, a 1 sets `eom_o` and ends the operation with `row_o` on the marked row. In other modes `marker_i` has no effect.
- R7: When the period of row NUM_ROWS-1 completes, in any mode, `ovf_o` is set and the operation ends with `row_o` held at NUM_ROWS-1; `row_o` never exceeds NUM_ROWS-1.
- R8: `eom_o` and `ovf_o` stay set until a `clr_i` pulse, which clears them in the next cycle; a flag being set in the same cycle wins over the clear.
- R9: A `start_i` pulse while idle with `start_row_i` >= NUM_ROWS sets `ovf_o` in the next cycle. The block stays idle and `row_o` is unchanged.
- R10: `start_i` while busy is ignored: the row, the mode and the timing carry on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle command pulse |
| mode_i | input | 2 | Operation mode, sampled with start_i |
| start_row_i | input | ADDR_W | Start row, sampled with start_i |
| stop_i | input | 1 | Request to end after the current row |
| marker_i | input | 1 | End-of-message marker bit of the current row |
| clr_i | input | 1 | Clears both sticky flags |
| row_o | output | ROW_W | Current row pointer |
| busy_o | output | 1 | Operation in progress |
| rac_pull_o | output | 1 | Row clock pull-down enable (1 = line low) |
| eom_o | output | 1 | End-of-message flag |
| ovf_o | output | 1 | Overflow flag |

## Verification
The assertions assume that the phase parameters are at least one tick and that `marker_i` is a plain level that is valid in the last cycle of each row period. They also assume that `start_i`, `stop_i` and `clr_i` are synchronous pulses that are never X after reset. The bench drives every input on the falling clock edge and holds each command for exactly one cycle. It changes `marker_i` only between row boundaries, which keeps the marker sample unambiguous. It also keeps start rows inside 16 bits, so the range check sees every out-of-range value it is meant to catch.

// File: rtl/msg_row_pkg.sv
package msg_row_pkg;

    typedef enum logic [1:0] {
        MODE_REC  = 2'b00,
        MODE_PLAY = 2'b01,
        MODE_FFWD = 2'b10,
        MODE_ALT  = 2'b11
    } seq_mode_e;

    typedef enum logic {
        PH_REL  = 1'b0,
        PH_PULL = 1'b1
    } rac_phase_e;

    typedef struct packed {
        logic      run;
        seq_mode_e mode;
        logic      stop_pend;
    } ctrl_state_t;

    typedef struct packed {
        logic eom;
        logic ovf;
    } flag_state_t;

endpackage

// File: rtl/mrs_row_timer.sv
module mrs_row_timer
    import msg_row_pkg::*;
#(
    parameter int HI_TICKS    = 8,
    parameter int LO_TICKS    = 2,
    parameter int FF_HI_TICKS = 4,
    parameter int FF_LO_TICKS = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic ffwd_i,
    output logic pull_o,
    output logic row_end_o
);

    localparam int MAX_N = (HI_TICKS > LO_TICKS) ? HI_TICKS : LO_TICKS;
    localparam int MAX_F = (FF_HI_TICKS > FF_LO_TICKS) ? FF_HI_TICKS : FF_LO_TICKS;
    localparam int MAX_T = (MAX_N > MAX_F) ? MAX_N : MAX_F;
    localparam int CNT_W = $clog2(MAX_T + 1);

    localparam logic [CNT_W-1:0] HI_LAST    = CNT_W'(HI_TICKS - 1);
    localparam logic [CNT_W-1:0] LO_LAST    = CNT_W'(LO_TICKS - 1);
    localparam logic [CNT_W-1:0] FF_HI_LAST = CNT_W'(FF_HI_TICKS - 1);
    localparam logic [CNT_W-1:0] FF_LO_LAST = CNT_W'(FF_LO_TICKS - 1);

    typedef struct packed {
        rac_phase_e       phase;
        logic [CNT_W-1:0] cnt;
    } tmr_state_t;

    tmr_state_t       st_d, st_q;
    logic [CNT_W-1:0] hi_last, lo_last;
    logic             row_end;

    always_comb begin
        hi_last = ffwd_i ? FF_HI_LAST : HI_LAST;
        lo_last = ffwd_i ? FF_LO_LAST : LO_LAST;
        row_end = run_i && (st_q.phase == PH_PULL) && (st_q.cnt == lo_last);
        st_d    = st_q;
        if (!run_i) begin
            st_d.phase = PH_REL;
            st_d.cnt   = '0;
        end else if (st_q.phase == PH_REL) begin
            if (st_q.cnt == hi_last) begin
                st_d.phase = PH_PULL;
                st_d.cnt   = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end else if (row_end) begin
            st_d.phase = PH_REL;
            st_d.cnt   = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.phase <= PH_REL;
            st_q.cnt   <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pull_o    = (st_q.phase == PH_PULL);
    assign row_end_o = row_end;

    // R3: the phase counter never passes the longest phase
    assert_phase_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CNT_W'(MAX_T - 1));

    // R3: a row ends only from the pulled phase, and the next period starts released
    assert_restart_released_R3: assert property (@(posedge clk) disable iff (!rst_n)
        row_end_o |=> !pull_o);

endmodule

// File: rtl/mrs_row_counter.sv
module mrs_row_counter #(
    parameter int NUM_ROWS = 2400,
    parameter int ADDR_W   = 16,
    localparam int ROW_W   = $clog2(NUM_ROWS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [ADDR_W-1:0] load_val_i,
    input  logic              adv_i,
    output logic [ROW_W-1:0]  row_o,
    output logic              last_o,
    output logic              bad_addr_o
);

    localparam logic [ADDR_W-1:0] ROW_LIMIT = ADDR_W'(NUM_ROWS);
    localparam logic [ROW_W-1:0]  ROW_LAST  = ROW_W'(NUM_ROWS - 1);

    logic [ROW_W-1:0] row_d, row_q;
    logic             bad_addr;

    always_comb begin
        bad_addr = (load_val_i >= ROW_LIMIT);
        row_d    = row_q;
        if (load_i && !bad_addr) begin
            row_d = ROW_W'(load_val_i);
        end else if (adv_i) begin
            row_d = row_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            row_q <= '0;
        end else begin
            row_q <= row_d;
        end
    end

    assign row_o      = row_q;
    assign last_o     = (row_q == ROW_LAST);
    assign bad_addr_o = bad_addr;

    // R7: pointer stays inside the store
    assert_row_in_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
        row_q <= ROW_LAST);

    // R7: the controller never asks to step past the last row
    assert_no_step_past_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
        adv_i |-> !last_o);

endmodule

// File: rtl/mrs_flags.sv
module mrs_flags
    import msg_row_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_eom_i,
    input  logic set_ovf_i,
    input  logic clr_i,
    output logic eom_o,
    output logic ovf_o
);

    flag_state_t fl_d, fl_q;

    always_comb begin
        fl_d = fl_q;
        if (clr_i) begin
            fl_d.eom = 1'b0;
            fl_d.ovf = 1'b0;
        end
        if (set_eom_i) fl_d.eom = 1'b1;
        if (set_ovf_i) fl_d.ovf = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fl_q <= '0;
        end else begin
            fl_q <= fl_d;
        end
    end

    assign eom_o = fl_q.eom;
    assign ovf_o = fl_q.ovf;

    // R8: flags hold until cleared
    assert_eom_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (eom_o && !clr_i) |=> eom_o);
    assert_ovf_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_o && !clr_i) |=> ovf_o);

    // R8: a set in the clear cycle wins
    assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && set_ovf_i) |=> ovf_o);

endmodule

// File: rtl/msg_row_sequencer.sv
module msg_row_sequencer
    import msg_row_pkg::*;
#(
    parameter int NUM_ROWS    = 2400,
    parameter int ADDR_W      = 16,
    parameter int HI_TICKS    = 21_875_000,
    parameter int LO_TICKS    = 3_125_000,
    parameter int FF_HI_TICKS = 2_734_375,
    parameter int FF_LO_TICKS = 390_625,
    localparam int ROW_W      = $clog2(NUM_ROWS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [1:0]        mode_i,
    input  logic [ADDR_W-1:0] start_row_i,
    input  logic              stop_i,
    input  logic              marker_i,
    input  logic              clr_i,
    output logic [ROW_W-1:0]  row_o,
    output logic              busy_o,
    output logic              rac_pull_o,
    output logic              eom_o,
    output logic              ovf_o
);

    ctrl_state_t ctl_d, ctl_q;

    logic row_end, last_row, bad_addr;
    logic start_ok, start_bad, hit_eom, hit_end, halt, adv, load;

    always_comb begin
        start_ok  = start_i && !ctl_q.run && !bad_addr;
        start_bad = start_i && !ctl_q.run && bad_addr;
        load      = start_i && !ctl_q.run;
        hit_eom   = row_end && (ctl_q.mode == MODE_PLAY) && marker_i;
        hit_end   = row_end && last_row;
        halt      = row_end && (hit_eom || hit_end || ctl_q.stop_pend || stop_i);
        adv       = row_end && !halt;

        ctl_d = ctl_q;
        if (start_ok) begin
            ctl_d.run       = 1'b1;
            ctl_d.mode      = seq_mode_e'(mode_i);
            ctl_d.stop_pend = 1'b0;
        end else if (halt) begin
            ctl_d.run       = 1'b0;
            ctl_d.stop_pend = 1'b0;
        end else if (ctl_q.run && stop_i) begin
            ctl_d.stop_pend = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q.run       <= 1'b0;
            ctl_q.mode      <= MODE_REC;
            ctl_q.stop_pend <= 1'b0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    mrs_row_timer #(
        .HI_TICKS    (HI_TICKS),
        .LO_TICKS    (LO_TICKS),
        .FF_HI_TICKS (FF_HI_TICKS),
        .FF_LO_TICKS (FF_LO_TICKS)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (ctl_q.run),
        .ffwd_i    (ctl_q.mode == MODE_FFWD),
        .pull_o    (rac_pull_o),
        .row_end_o (row_end)
    );

    mrs_row_counter #(
        .NUM_ROWS (NUM_ROWS),
        .ADDR_W   (ADDR_W)
    ) u_rows (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (load),
        .load_val_i (start_row_i),
        .adv_i      (adv),
        .row_o      (row_o),
        .last_o     (last_row),
        .bad_addr_o (bad_addr)
    );

    mrs_flags u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_eom_i (hit_eom),
        .set_ovf_i (start_bad || hit_end),
        .clr_i     (clr_i),
        .eom_o     (eom_o),
        .ovf_o     (ovf_o)
    );

    assign busy_o = ctl_q.run;

    // R1: row clock released while idle
    assert_idle_released_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !rac_pull_o);

    // R3: row pointer moves only at a row boundary
    assert_row_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !row_end) |=> $stable(row_o));

    // R6: end-of-message appears only out of a playback operation
    assert_eom_from_play_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(eom_o) |-> ($past(ctl_q.mode) == MODE_PLAY && $past(busy_o)));

    // R9: out-of-range start raises overflow and stays idle
    assert_bad_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && start_row_i >= ADDR_W'(NUM_ROWS)) |=> (ovf_o && !busy_o));

    // R10: a start while busy leaves the mode alone
    assert_busy_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> $stable(ctl_q.mode));

endmodule

// File: tb/msg_row_sequencer_tb.sv
module msg_row_sequencer_tb;

    localparam int NROWS = 8;
    localparam int AW    = 16;
    localparam int RW    = $clog2(NROWS);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [1:0]    mode_i = 2'b00;
    logic [AW-1:0] start_row_i = '0;
    logic          stop_i = 1'b0;
    logic          marker_i = 1'b0;
    logic          clr_i = 1'b0;
    logic [RW-1:0] row_o;
    logic          busy_o, rac_pull_o, eom_o, ovf_o;

    int total = 0;
    int bad   = 0;
    logic done = 1'b0;

    always #4 clk = ~clk;

    msg_row_sequencer #(
        .NUM_ROWS    (NROWS),
        .ADDR_W      (AW),
        .HI_TICKS    (6),
        .LO_TICKS    (2),
        .FF_HI_TICKS (3),
        .FF_LO_TICKS (1)
    ) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .mode_i      (mode_i),
        .start_row_i (start_row_i),
        .stop_i      (stop_i),
        .marker_i    (marker_i),
        .clr_i       (clr_i),
        .row_o       (row_o),
        .busy_o      (busy_o),
        .rac_pull_o  (rac_pull_o),
        .eom_o       (eom_o),
        .ovf_o       (ovf_o)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic start_op(input logic [1:0] m, input logic [AW-1:0] a);
        @(negedge clk);
        start_i = 1'b1; mode_i = m; start_row_i = a;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic pulse_clr();
        clr_i = 1'b1;
        step(1);
        clr_i = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1", "busy", busy_o, 0);
        chk("R1", "row", row_o, 0);
        chk("R1", "pull", rac_pull_o, 0);
        chk("R1", "eom", eom_o, 0);
        chk("R1", "ovf", ovf_o, 0);
    endtask

    task automatic t_record();
        marker_i = 1'b1;
        start_op(2'b00, 16'd2);
        chk("R2", "row after load", row_o, 2);
        chk("R2", "busy after load", busy_o, 1);
        step(5);
        chk("R3", "pull last released tick", rac_pull_o, 0);
        step(1);
        chk("R3", "pull first low tick", rac_pull_o, 1);
        step(1);
        chk("R3", "pull second low tick", rac_pull_o, 1);
        step(1);
        chk("R3", "row advanced", row_o, 3);
        chk("R3", "pull restart", rac_pull_o, 0);
        chk("R6", "eom ignored in record", eom_o, 0);
        stop_i = 1'b1;
        step(1);
        stop_i = 1'b0;
        step(6);
        chk("R4", "busy until period end", busy_o, 1);
        step(1);
        chk("R4", "idle after stop", busy_o, 0);
        chk("R4", "row kept", row_o, 3);
        marker_i = 1'b0;
    endtask

    task automatic t_stop_first_row();
        start_op(2'b11, 16'd0);
        chk("R2", "alt mode load", row_o, 0);
        stop_i = 1'b1;
        step(1);
        stop_i = 1'b0;
        step(6);
        chk("R4", "pull before stop end", rac_pull_o, 1);
        chk("R4", "still busy", busy_o, 1);
        step(1);
        chk("R4", "stopped", busy_o, 0);
        chk("R4", "row stays 0", row_o, 0);
    endtask

    task automatic t_ffwd_overflow();
        marker_i = 1'b1;
        start_op(2'b10, 16'd5);
        chk("R5", "ff load row", row_o, 5);
        step(2);
        chk("R5", "ff released", rac_pull_o, 0);
        step(1);
        chk("R5", "ff low", rac_pull_o, 1);
        step(1);
        chk("R5", "ff advance", row_o, 6);
        step(4);
        chk("R5", "ff last row", row_o, 7);
        step(3);
        chk("R7", "busy before end", busy_o, 1);
        chk("R7", "ovf not yet", ovf_o, 0);
        step(1);
        chk("R7", "halted at end", busy_o, 0);
        chk("R7", "ovf set", ovf_o, 1);
        chk("R7", "row held last", row_o, 7);
        chk("R6", "eom ignored in ff", eom_o, 0);
        marker_i = 1'b0;
        step(5);
        chk("R8", "ovf sticky", ovf_o, 1);
        pulse_clr();
        chk("R8", "ovf cleared", ovf_o, 0);
    endtask

    task automatic t_playback_eom();
        start_op(2'b01, 16'd1);
        step(8);
        chk("R6", "play row 2", row_o, 2);
        chk("R6", "no eom yet", eom_o, 0);
        marker_i = 1'b1;
        step(7);
        chk("R6", "busy in marked row", busy_o, 1);
        step(1);
        chk("R6", "eom set", eom_o, 1);
        chk("R6", "halt on eom", busy_o, 0);
        chk("R6", "row on marked", row_o, 2);
        marker_i = 1'b0;
        step(3);
        chk("R8", "eom sticky", eom_o, 1);
        pulse_clr();
        chk("R8", "eom cleared", eom_o, 0);
    endtask

    task automatic t_bad_addr();
        start_op(2'b00, 16'd8);
        chk("R9", "ovf on bad start", ovf_o, 1);
        chk("R9", "stays idle", busy_o, 0);
        chk("R9", "row unchanged", row_o, 2);
        pulse_clr();
        start_op(2'b01, 16'hFFFF);
        chk("R9", "ovf on max start", ovf_o, 1);
        chk("R9", "idle on max start", busy_o, 0);
        pulse_clr();
    endtask

    task automatic t_busy_start();
        marker_i = 1'b1;
        start_op(2'b00, 16'd0);
        step(2);
        start_i = 1'b1; mode_i = 2'b01; start_row_i = 16'd5;
        step(1);
        start_i = 1'b0;
        step(5);
        chk("R10", "row not reloaded", row_o, 1);
        chk("R10", "mode not changed", eom_o, 0);
        chk("R10", "still busy", busy_o, 1);
        marker_i = 1'b0;
        stop_i = 1'b1;
        step(1);
        stop_i = 1'b0;
        step(10);
        chk("R4", "idle after busy test", busy_o, 0);
    endtask

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        t_reset();
        t_record();
        t_stop_first_row();
        t_ffwd_overflow();
        t_playback_eom();
        t_bad_addr();
        t_busy_start();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #(8 * 20000);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule